// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer

This block runs an analog acquisition from a short channel list. The host writes channel codes into a small list memory. Each time the selected pacing source fires, the sequencer makes one pass over the list. For every entry it raises a conversion request toward an external converter, waits for the acknowledge, and stores the returned sample in an external buffer at a write pointer that then steps by one. A reserved channel code, all ones, marks the end of a pass. A list that has no such code ends after its final location.

The pacing source can be the host start strobe, an edge of an event line, a threshold trigger, a bus strobe, or an internal divided clock. The event line has a selectable edge and an optional delay counter that runs before the scan begins. In single mode the block makes one pass and then returns to idle. In multiple mode it returns to list entry 0 and waits for the next pacing tick until it has completed the programmed number of scans.

The host can read the write pointer and the scan count at any time. It can set a pointer mark or a scan mark and receive a sticky flag when that mark is reached, so it can pace its reads of the buffer. A stop strobe lets any conversion already in flight finish and then returns the block to idle.

Top module: `scan_seq`

## Requirements
- R1: Synchronous reset clears every state register and output: busy, cnv_req, buf_we, wr_ptr, scan_cnt, irq_ptr and irq_scan are all 0 after reset.
- R2: Only a rising edge of host_start_wr counts as a start, so a strobe held high for several cycles acts once. A start while idle arms the block: busy goes to 1 and wr_ptr, scan_cnt, irq_ptr and irq_scan clear to 0. A start while armed does not re-arm the block.
- R3: Each pass reads the list from entry 0 in ascending address order and requests one conversion per entry, with the entry as cnv_chan. The code all-ones (0x3F for a 6-bit code) ends the pass and is never requested. A list with no terminator ends after entry 2^LIST_AW-1.
- R4: Each cnv_ack received while a request is pending produces one buffer write on the following cycle, with buf_wdata equal to cnv_data and buf_addr equal to the pointer before the write. wr_ptr then advances by one, modulo 2^BUF_AW.
- R5: cnv_req stays high with cnv_chan unchanged until cnv_ack is seen.
- R6: cfg_src selects the pacing tick: 0 host start, 1 event edge, 2 thr_trig, 3 bus_strobe, 4 internal divider with a period of cfg_div+1 cycles, and 5 to 7 no tick at all. A tick that arrives while the block is armed and waiting starts one pass. A tick that arrives during a pass or while idle is ignored.
- R7: When cfg_multi is 0 the block makes one pass and goes idle. When cfg_multi is 1 it keeps making passes until scan_cnt reaches cfg_scans, where a value of 0 counts as 1, and then goes idle. scan_cnt steps up by one at the end of each pass.
- R8: When cfg_evt_neg is 0 the event tick fires on a rising edge of evt_in. When it is 1 the tick fires on a falling edge instead, and a rising edge has no effect.
- R9: With cfg_dly_en set to 1, an event edge loads a delay counter with cfg_dly. The first conversion request then appears cfg_dly+1 cycles later than it would with the delay off. With the delay off, the request appears on the third rising clock edge after the edge on evt_in is sampled.
- R10: With cfg_ptr_ie set to 1, irq_ptr sets on the same edge as the buffer write that brings wr_ptr to cfg_ptr_mark. It stays set until the next arm or reset. With cfg_ptr_ie at 0 it stays at 0.
- R11: With cfg_scan_ie set to 1, irq_scan sets when scan_cnt steps to cfg_scan_mark. It stays set until the next arm or reset. With cfg_scan_ie at 0 it stays at 0.
- R12: host_stop_wr returns the block to idle. If a conversion is pending, the block first waits for its acknowledge and writes that sample, and it issues no further requests afterwards. A stop while the block is waiting for a tick takes effect on the next edge.
- R13: busy is 1 from arm until the block returns to idle, and cnv_req is never high while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_we | input | 1 | Channel list write enable |
| list_addr | input | LIST_AW | Channel list write address |
| list_wdata | input | CH_W | Channel code to store |
| cfg_src | input | 3 | Pacing source select |
| cfg_multi | input | 1 | Multiple-scan mode |
| cfg_scans | input | SCAN_W | Scan count target in multiple mode |
| cfg_div | input | DIV_W | Internal divider terminal count |
| cfg_dly_en | input | 1 | Enable the event delay counter |
| cfg_dly | input | DLY_W | Event delay length |
| cfg_evt_neg | input | 1 | Event falling-edge select |
| cfg_ptr_mark | input | BUF_AW | Pointer mark for the throttle flag |
| cfg_ptr_ie | input | 1 | Enable the pointer mark flag |
| cfg_scan_mark | input | SCAN_W | Scan mark for the throttle flag |
| cfg_scan_ie | input | 1 | Enable the scan mark flag |
| host_start_wr | input | 1 | Start register write strobe |
| host_stop_wr | input | 1 | Stop register write strobe |
| evt_in | input | 1 | External event line |
| thr_trig | input | 1 | Threshold trigger pulse |
| bus_strobe | input | 1 | Bus strobe pulse |
| cnv_req | output | 1 | Conversion request |
| cnv_chan | output | CH_W | Channel to convert |
| cnv_ack | input | 1 | Conversion done |
| cnv_data | input | DATA_W | Conversion result |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | BUF_AW | Buffer write address |
| buf_wdata | output | DATA_W | Buffer write data |
| wr_ptr | output | BUF_AW | Current buffer write pointer |
| scan_cnt | output | SCAN_W | Completed scan count |
| busy | output | 1 | Acquisition active |
| irq_ptr | output | 1 | Pointer mark reached |
| irq_scan | output | 1 | Scan mark reached |

## Verification
The bench sweeps list lengths from empty to four entries, scan counts from one to three and all five pacing sources. For every write it checks the channel, the data and the address. A design that misread the terminator would request channel all-ones or stop one entry early. A design that reloaded the list index wrongly would repeat or skip entries on the second and later scans.

The bench also runs a full list with no terminator for enough scans to make the pointer wrap. This exposes an off-by-one at the last list location and a pointer that saturates instead of wrapping. Separate cases measure the event delay exactly and the divider spacing. They hold a strobe high to catch repeated starts, and they send a stop during a pending conversion to catch a design that drops the sample or keeps requesting.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    SRC_HOST   = 3'd0,
    SRC_EVENT  = 3'd1,
    SRC_THRESH = 3'd2,
    SRC_STROBE = 3'd3,
    SRC_DIV    = 3'd4
  } pace_src_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_READ  = 3'd2,
    ST_CHECK = 3'd3,
    ST_CONV  = 3'd4,
    ST_EOS   = 3'd5
  } seq_state_e;

endpackage

// File: rtl/scan_seq_list_ram.sv
module scan_seq_list_ram #(
  parameter int AW = 4,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // plain write port plus registered read port, shaped for block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/scan_seq_pacer.sv
module scan_seq_pacer
  import scan_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [2:0]       src,
  input  logic [DIV_W-1:0] div,
  input  logic             dly_en,
  input  logic [DLY_W-1:0] dly,
  input  logic             evt_neg,
  input  logic             start_wr,
  input  logic             evt_in,
  input  logic             thr_trig,
  input  logic             bus_strobe,
  output logic             start_pls,
  output logic             tick
);
  logic             start_q, start_d, evt_q, dly_act;
  logic [DLY_W-1:0] dly_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             evt_edge, evt_tick, div_tick;

  assign start_pls = start_wr & ~start_q;
  assign evt_edge  = evt_neg ? (evt_q & ~evt_in) : (~evt_q & evt_in);
  assign evt_tick  = dly_en ? (dly_act && dly_cnt == '0) : evt_edge;
  assign div_tick  = active && (div_cnt == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      start_d <= 1'b0;
      evt_q   <= evt_in;
      dly_act <= 1'b0;
      dly_cnt <= '0;
      div_cnt <= '0;
    end else begin
      start_q <= start_wr;
      start_d <= start_pls;
      evt_q   <= evt_in;
      if (evt_edge && dly_en) begin
        dly_act <= 1'b1;
        dly_cnt <= dly;
      end else if (dly_act) begin
        if (dly_cnt == '0) dly_act <= 1'b0;
        else               dly_cnt <= dly_cnt - DLY_W'(1);
      end
      if (!active || div_cnt == div) div_cnt <= '0;
      else                           div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  always_comb begin
    case (pace_src_e'(src))
      SRC_HOST:   tick = start_d;
      SRC_EVENT:  tick = evt_tick;
      SRC_THRESH: tick = thr_trig;
      SRC_STROBE: tick = bus_strobe;
      SRC_DIV:    tick = div_tick;
      default:    tick = 1'b0;
    endcase
  end

  // a held start strobe yields one pulse only
  assert_single_start_R2: assert property (@(posedge clk) disable iff (rst)
    start_pls |=> !start_pls);

  // the delay counter never runs while idle in its final state twice
  assert_delay_done_R9: assert property (@(posedge clk) disable iff (rst)
    (dly_act && dly_cnt == '0 && !(evt_edge && dly_en)) |=> !dly_act);
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int CH_W    = 6,
  parameter int LIST_AW = 4,
  parameter int DATA_W  = 16,
  parameter int BUF_AW  = 8,
  parameter int SCAN_W  = 8,
  parameter int DIV_W   = 8,
  parameter int DLY_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               list_we,
  input  logic [LIST_AW-1:0] list_addr,
  input  logic [CH_W-1:0]    list_wdata,
  input  logic [2:0]         cfg_src,
  input  logic               cfg_multi,
  input  logic [SCAN_W-1:0]  cfg_scans,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               cfg_dly_en,
  input  logic [DLY_W-1:0]   cfg_dly,
  input  logic               cfg_evt_neg,
  input  logic [BUF_AW-1:0]  cfg_ptr_mark,
  input  logic               cfg_ptr_ie,
  input  logic [SCAN_W-1:0]  cfg_scan_mark,
  input  logic               cfg_scan_ie,
  input  logic               host_start_wr,
  input  logic               host_stop_wr,
  input  logic               evt_in,
  input  logic               thr_trig,
  input  logic               bus_strobe,
  output logic               cnv_req,
  output logic [CH_W-1:0]    cnv_chan,
  input  logic               cnv_ack,
  input  logic [DATA_W-1:0]  cnv_data,
  output logic               buf_we,
  output logic [BUF_AW-1:0]  buf_addr,
  output logic [DATA_W-1:0]  buf_wdata,
  output logic [BUF_AW-1:0]  wr_ptr,
  output logic [SCAN_W-1:0]  scan_cnt,
  output logic               busy,
  output logic               irq_ptr,
  output logic               irq_scan
);
  localparam logic [CH_W-1:0]    TERM = '1;
  localparam logic [LIST_AW-1:0] LAST = '1;

  seq_state_e         state;
  logic [LIST_AW-1:0] idx;
  logic [CH_W-1:0]    list_q;
  logic               stop_pend, stop_any, start_pls, tick;
  logic [BUF_AW-1:0]  ptr_nxt;
  logic [SCAN_W-1:0]  scan_nxt;

  assign busy     = (state != ST_IDLE);
  assign stop_any = stop_pend | host_stop_wr;
  assign ptr_nxt  = wr_ptr + BUF_AW'(1);
  assign scan_nxt = scan_cnt + SCAN_W'(1);

  scan_seq_list_ram #(.AW(LIST_AW), .DW(CH_W)) i_list (
    .clk(clk), .we(list_we), .waddr(list_addr), .wdata(list_wdata),
    .raddr(idx), .rdata(list_q)
  );

  scan_seq_pacer #(.DIV_W(DIV_W), .DLY_W(DLY_W)) i_pacer (
    .clk(clk), .rst(rst), .active(busy), .src(cfg_src), .div(cfg_div),
    .dly_en(cfg_dly_en), .dly(cfg_dly), .evt_neg(cfg_evt_neg),
    .start_wr(host_start_wr), .evt_in(evt_in), .thr_trig(thr_trig),
    .bus_strobe(bus_strobe), .start_pls(start_pls), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      stop_pend <= 1'b0;
      cnv_req   <= 1'b0;
      cnv_chan  <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      wr_ptr    <= '0;
      scan_cnt  <= '0;
      irq_ptr   <= 1'b0;
      irq_scan  <= 1'b0;
    end else begin
      buf_we <= 1'b0;
      if (host_stop_wr && state != ST_IDLE) stop_pend <= 1'b1;
      case (state)
        ST_IDLE: if (start_pls) begin
          state     <= ST_WAIT;
          wr_ptr    <= '0;
          scan_cnt  <= '0;
          irq_ptr   <= 1'b0;
          irq_scan  <= 1'b0;
          stop_pend <= 1'b0;
        end
        ST_WAIT: begin
          if (stop_any) begin
            state     <= ST_IDLE;
            stop_pend <= 1'b0;
          end else if (tick) begin
            idx   <= '0;
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (stop_any) begin
            state     <= ST_IDLE;
            stop_pend <= 1'b0;
          end else begin
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (stop_any) begin
            state     <= ST_IDLE;
            stop_pend <= 1'b0;
          end else if (list_q == TERM) begin
            state <= ST_EOS;
          end else begin
            cnv_req  <= 1'b1;
            cnv_chan <= list_q;
            state    <= ST_CONV;
          end
        end
        ST_CONV: if (cnv_ack) begin
          cnv_req   <= 1'b0;
          buf_we    <= 1'b1;
          buf_addr  <= wr_ptr;
          buf_wdata <= cnv_data;
          wr_ptr    <= ptr_nxt;
          if (cfg_ptr_ie && ptr_nxt == cfg_ptr_mark) irq_ptr <= 1'b1;
          idx <= idx + LIST_AW'(1);
          if (stop_any) begin
            state     <= ST_IDLE;
            stop_pend <= 1'b0;
          end else if (idx == LAST) begin
            state <= ST_EOS;
          end else begin
            state <= ST_READ;
          end
        end
        ST_EOS: begin
          scan_cnt <= scan_nxt;
          if (cfg_scan_ie && scan_nxt == cfg_scan_mark) irq_scan <= 1'b1;
          if (stop_any || !cfg_multi || scan_nxt >= cfg_scans) begin
            state     <= ST_IDLE;
            stop_pend <= 1'b0;
          end else begin
            state <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cnv_req && !cnv_ack) |=> (cnv_req && $stable(cnv_chan)));

  assert_no_term_req_R3: assert property (@(posedge clk) disable iff (rst)
    cnv_req |-> (cnv_chan != TERM));

  assert_write_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> ($past(cnv_ack) && $past(cnv_req)));

  assert_ptr_follows_write_R4: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (wr_ptr == buf_addr + BUF_AW'(1)));

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cnv_req);

  assert_scan_step_R7: assert property (@(posedge clk) disable iff (rst)
    (scan_cnt != $past(scan_cnt)) |->
      (scan_cnt == $past(scan_cnt) + SCAN_W'(1) || scan_cnt == '0));
endmodule

// File: tb/test_scan_seq.sv
module test_scan_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        list_we = 1'b0;
  logic [3:0]  list_addr = '0;
  logic [5:0]  list_wdata = '0;
  logic [2:0]  cfg_src = '0;
  logic        cfg_multi = 1'b0;
  logic [7:0]  cfg_scans = '0;
  logic [7:0]  cfg_div = '0;
  logic        cfg_dly_en = 1'b0;
  logic [7:0]  cfg_dly = '0;
  logic        cfg_evt_neg = 1'b0;
  logic [7:0]  cfg_ptr_mark = '0;
  logic        cfg_ptr_ie = 1'b0;
  logic [7:0]  cfg_scan_mark = '0;
  logic        cfg_scan_ie = 1'b0;
  logic        host_start_wr = 1'b0, host_stop_wr = 1'b0;
  logic        evt_in = 1'b0, thr_trig = 1'b0, bus_strobe = 1'b0;
  logic        cnv_req, cnv_ack = 1'b0;
  logic [5:0]  cnv_chan;
  logic [15:0] cnv_data = '0;
  logic        buf_we, busy, irq_ptr, irq_scan;
  logic [7:0]  buf_addr, wr_ptr, scan_cnt;
  logic [15:0] buf_wdata;

  scan_seq i_scan_seq (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int nw = 0, nr = 0, seq = 0, ptr_rises = 0, ptr_rise_nw = 0, scan_rises = 0, scan_rise_val = 0;
  int wa [2048];
  int wd [2048];
  int rt [2048];
  bit hold_ack = 1'b0, req_q = 1'b0, pq = 1'b0, sq = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog R13 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  // converter model and output monitor
  always @(negedge clk) begin
    if (!hold_ack && cnv_req && !cnv_ack) begin
      cnv_ack  = 1'b1;
      cnv_data = {cnv_chan, 10'(seq)};
      seq++;
    end else begin
      cnv_ack = 1'b0;
    end
    if (buf_we) begin
      wa[nw & 2047] = int'(buf_addr);
      wd[nw & 2047] = int'(buf_wdata);
      nw++;
    end
    if (cnv_req && !req_q) begin
      rt[nr & 2047] = cyc;
      nr++;
    end
    req_q = cnv_req;
    if (irq_ptr && !pq) begin ptr_rises++; ptr_rise_nw = nw; end
    pq = irq_ptr;
    if (irq_scan && !sq) begin scan_rises++; scan_rise_val = int'(scan_cnt); end
    sq = irq_scan;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int chan_of(input int i, input int l, input int s);
    return (i * 5 + l + s * 3 + 1) % 48;
  endfunction

  task automatic program_list(input int l, input int s);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      list_we    = 1'b1;
      list_addr  = 4'(i);
      list_wdata = (i < l) ? 6'(chan_of(i, l, s)) : 6'h3F;
    end
    @(negedge clk);
    list_we = 1'b0;
  endtask

  task automatic strobe_start();
    @(negedge clk); host_start_wr = 1'b1;
    @(negedge clk); host_start_wr = 1'b0;
  endtask

  task automatic strobe_stop();
    @(negedge clk); host_stop_wr = 1'b1;
    @(negedge clk); host_stop_wr = 1'b0;
  endtask

  task automatic pulse_src(input int s);
    @(negedge clk);
    case (s)
      0: host_start_wr = 1'b1;
      1: evt_in = 1'b1;
      2: thr_trig = 1'b1;
      3: bus_strobe = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    host_start_wr = 1'b0; evt_in = 1'b0; thr_trig = 1'b0; bus_strobe = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  task automatic run_case(input int l, input int s, input bit multi, input int src, input int div);
    int e, nw0, seq0, bad;
    cfg_src = 3'(src); cfg_multi = multi; cfg_scans = 8'(s); cfg_div = 8'(div);
    program_list(l, src);
    nw0 = nw; seq0 = seq;
    strobe_start();
    for (int it = 0; it < s + 4; it++) begin
      repeat (30) @(negedge clk);
      if (!busy) break;
      if (src != 4) pulse_src(src);
    end
    wait_idle(4000);
    e = multi ? ((s == 0) ? 1 : s) : 1;
    chk("R7 scan count", int'(scan_cnt), e % 256);
    chk("R4 final pointer", int'(wr_ptr), (l * e) % 256);
    chk("R3 write count", nw - nw0, l * e);
    bad = 0;
    for (int k = 0; k < nw - nw0 && l > 0; k++) begin
      int v;
      v = wd[(nw0 + k) & 2047];
      if (wa[(nw0 + k) & 2047] != k % 256) bad++;
      if ((v >> 10) != chan_of(k % l, l, src)) bad++;
      if ((v & 1023) != ((seq0 + k) & 1023)) bad++;
    end
    chk("R3 R4 entry order and data", bad, 0);
    chk("R13 idle after run", int'(busy), 0);
  endtask

  task automatic delay_probe(input bit en, input int d, output int k);
    cfg_src = 3'd1; cfg_multi = 1'b1; cfg_scans = 8'd2; cfg_dly_en = en; cfg_dly = 8'(d);
    strobe_start();
    repeat (5) @(negedge clk);
    evt_in = 1'b1;
    k = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (cnv_req) break;
    end
    evt_in = 1'b0;
    strobe_stop();
    wait_idle(50);
  endtask

  initial begin
    int k0, k1, k2, n0, r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 cnv_req", int'(cnv_req), 0);
    chk("R1 buf_we", int'(buf_we), 0);
    chk("R1 wr_ptr", int'(wr_ptr), 0);
    chk("R1 scan_cnt", int'(scan_cnt), 0);
    chk("R1 irq flags", int'({irq_ptr, irq_scan}), 0);

    // R3 R6 R7 sweep over list lengths, scan counts and pacing sources
    for (int src = 0; src < 5; src++)
      for (int l = 0; l < 5; l++)
        for (int s = 1; s < 4; s++)
          run_case(l, s, 1'b1, src, 29);
    run_case(3, 3, 1'b0, 2, 29);      // R7 single mode ignores the count
    run_case(2, 0, 1'b1, 3, 29);      // R7 zero target counts as one
    run_case(16, 17, 1'b1, 4, 59);    // R3 no terminator, R4 pointer wrap

    // R2 held strobe acts once; a second strobe paces the next scan
    cfg_src = 3'd0; cfg_multi = 1'b1; cfg_scans = 8'd3;
    program_list(2, 0);
    @(negedge clk); host_start_wr = 1'b1;
    repeat (4) @(negedge clk); host_start_wr = 1'b0;
    repeat (40) @(negedge clk);
    chk("R2 held start yields one scan", int'(scan_cnt), 1);
    chk("R2 armed", int'(busy), 1);
    strobe_start();
    repeat (40) @(negedge clk);
    chk("R2 start while armed paces, no re-arm", int'(scan_cnt), 2);
    strobe_stop();
    repeat (3) @(negedge clk);
    chk("R12 stop while waiting", int'(busy), 0);

    // R6 divider spacing
    for (int dv = 9; dv <= 14; dv += 5) begin
      cfg_src = 3'd4; cfg_div = 8'(dv); cfg_multi = 1'b1; cfg_scans = 8'd3;
      program_list(1, 4);
      r0 = nr;
      strobe_start();
      wait_idle(500);
      chk("R6 divider scans", nr - r0, 3);
      chk("R6 divider spacing a", rt[(r0 + 1) & 2047] - rt[r0 & 2047], dv + 1);
      chk("R6 divider spacing b", rt[(r0 + 2) & 2047] - rt[(r0 + 1) & 2047], dv + 1);
    end

    // R6 unused codes give no tick
    cfg_src = 3'd6; cfg_multi = 1'b1; cfg_scans = 8'd2;
    r0 = nr;
    strobe_start();
    pulse_src(0); pulse_src(1); pulse_src(2); pulse_src(3);
    repeat (20) @(negedge clk);
    chk("R6 unused source no scan", nr - r0, 0);
    chk("R13 still armed", int'(busy), 1);
    strobe_stop();
    repeat (2) @(negedge clk);

    // R9 event delay
    program_list(1, 1);
    delay_probe(1'b0, 0, k0);
    delay_probe(1'b1, 0, k1);
    delay_probe(1'b1, 5, k2);
    chk("R9 no delay latency", k0, 3);
    chk("R9 zero delay adds one", k1 - k0, 1);
    chk("R9 delay five adds six", k2 - k0, 6);
    cfg_dly_en = 1'b0;

    // R8 falling-edge polarity
    cfg_evt_neg = 1'b1; cfg_src = 3'd1; cfg_multi = 1'b1; cfg_scans = 8'd2;
    r0 = nr;
    strobe_start();
    repeat (5) @(negedge clk);
    evt_in = 1'b1;
    repeat (12) @(negedge clk);
    chk("R8 rising edge ignored when negative", nr - r0, 0);
    evt_in = 1'b0;
    repeat (12) @(negedge clk);
    chk("R8 falling edge starts scan", nr - r0, 1);
    strobe_stop();
    wait_idle(50);
    cfg_evt_neg = 1'b0;

    // R12 stop during a pending conversion
    cfg_src = 3'd2; cfg_multi = 1'b1; cfg_scans = 8'd3;
    program_list(3, 2);
    hold_ack = 1'b1;
    n0 = nw;
    strobe_start();
    pulse_src(2);
    for (int i = 0; i < 20 && !cnv_req; i++) @(negedge clk);
    strobe_stop();
    repeat (3) @(negedge clk);
    chk("R12 pending request kept", int'(cnv_req), 1);
    chk("R13 busy while converting", int'(busy), 1);
    hold_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 idle after pending ack", int'(busy), 0);
    chk("R12 pending sample written", nw - n0, 1);
    r0 = nr;
    pulse_src(2);
    repeat (15) @(negedge clk);
    chk("R12 R6 no request after stop", nr - r0, 0);

    // R10 R11 throttle flags
    cfg_src = 3'd2; cfg_multi = 1'b1; cfg_scans = 8'd3;
    cfg_ptr_mark = 8'd3; cfg_ptr_ie = 1'b1; cfg_scan_mark = 8'd2; cfg_scan_ie = 1'b1;
    program_list(2, 2);
    k0 = ptr_rises; k1 = scan_rises; n0 = nw;
    strobe_start();
    for (int it = 0; it < 3; it++) begin pulse_src(2); repeat (25) @(negedge clk); end
    wait_idle(200);
    chk("R10 pointer flag rose once", ptr_rises - k0, 1);
    chk("R10 pointer flag at mark", ptr_rise_nw - n0, 3);
    chk("R11 scan flag rose once", scan_rises - k1, 1);
    chk("R11 scan flag at mark", scan_rise_val, 2);
    chk("R10 flag sticky", int'(irq_ptr), 1);
    cfg_src = 3'd7;
    strobe_start();
    repeat (2) @(negedge clk);
    chk("R2 arm clears flags", int'({irq_ptr, irq_scan}), 0);
    strobe_stop();
    repeat (2) @(negedge clk);

    cfg_src = 3'd2; cfg_ptr_ie = 1'b0; cfg_scan_ie = 1'b0;
    k0 = ptr_rises; k1 = scan_rises;
    strobe_start();
    for (int it = 0; it < 3; it++) begin pulse_src(2); repeat (25) @(negedge clk); end
    wait_idle(200);
    chk("R10 disabled pointer flag", ptr_rises - k0, 0);
    chk("R11 disabled scan flag", scan_rises - k1, 0);

    // R1 reset mid-life clears state
    cfg_ptr_ie = 1'b1; cfg_src = 3'd6;
    strobe_start();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 scan_cnt after reset", int'(scan_cnt), 0);
    chk("R1 wr_ptr after reset", int'(wr_ptr), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule